// File: doc/BRIEF.md
# Two-Level Rotating Bus Arbiter

This block decides which of several masters on a shared parallel bus may start the next transaction. There are nine masters. Index 0 is the local bridge master. Indices 1 to 8 are the external masters. Every request input and grant output is active low.

A per-master priority vector places each master in either the high group or the low group. The high group is served by one rotating ring. The low group is served by a second rotating ring, and that whole ring occupies a single slot of the high ring. The slot sits after the highest-numbered position. As a result, each low-group member gets a turn only when that slot comes round.

The rotation pointers move only when a new transaction starts, which is seen as a falling edge on FRAME. Between starts, the grant follows the best active request under the current pointers. When nothing is requested, the grant stays parked on the last initiator. A configuration input can instead force parking on the bridge.

Grant changes obey a spacing rule that depends on bus state:
- When the bus is idle, one grant is removed and the next is given a clock later.
- When FRAME or IRDY is active, the hand-over happens in a single clock.

All pins are plain level signals. There is no streaming interface and no back-pressure.

Top module: `duo_ring_arbiter`

## Requirements
- R1: While reset is active, and in the first cycle after it, exactly the bridge grant is asserted: `gnt_n[0]` is low and every other bit is high.
- R2: In every cycle at most one bit of `gnt_n` is low.
- R3: With `prio_hi` = 9'h001 and all nine requests held, transaction initiators alternate. The sequence is bridge, external 1, bridge, external 2, and so on up to external 8, then the pattern repeats.
- R4: With `prio_hi` = 9'h00F and all requests held, initiators follow 0,1,2,3,4,0,1,2,3,5,0,1,2,3,6. Each cycle of the high ring hands the low group one turn, and that turn advances through 4..8.
- R5: When all `prio_hi` bits are 1, or all are 0, initiators rotate flat through 0,1,...,8 in ascending order.
- R6: A transaction start is a cycle where `frame_n` is low after being high. At each start, the initiator (the master granted at that edge) becomes the lowest priority in its group. The next higher index in the same ring becomes the highest. A low-group initiator also moves the high ring to just after the low slot.
- R7: Between transaction starts, the grant targets the highest-priority active request. If a higher-priority request appears, the current grant is removed, and the new grant appears on the following clock when the bus is idle.
- R8: With the bus idle (`frame_n` and `irdy_n` both high), a grant change always passes through one cycle with no grant. With `frame_n` or `irdy_n` low, the grant moves to the new master in one clock. A cycle with no grant is always followed by a grant.
- R9: With no request active and `park_local` low, the grant stays on the last transaction initiator. Directly after reset, that initiator is taken to be the bridge.
- R10: With no request active and `park_local` high, the grant moves to, and then stays on, the bridge.
- R11: Requests that come and go without a transaction start leave both rotation pointers unchanged. A master that loses the grant that way wins it back when it requests again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | 9 | Request per master, active low. Bit 0 is the bridge. |
| frame_n | input | 1 | Bus FRAME, active low. Its falling edge marks a transaction start. |
| irdy_n | input | 1 | Bus IRDY, active low. Used for busy detection. |
| prio_hi | input | 9 | Group per master: 1 means high group, 0 means low group |
| park_local | input | 1 | 1 forces idle parking on the bridge |
| gnt_n | output | 9 | Grant per master, active low |

## Verification
The hardest condition to reach is the long rotation of the low ring when it is nested inside the high ring. A low-group member only moves forward once per full lap of the high ring. Checking R4 therefore needs a bench-side master model that keeps starting transactions whenever a requesting master holds the grant. The initiator order is logged over fifteen starts.

The R11 case is also hard to reach from the ports. It needs requests that change while FRAME never falls, so the grant moves away from a master and later returns to it. The stimulus builds this case by toggling one request with the bus held idle. A cycle-accurate behavioural model in the bench shadows every clock.

// File: rtl/duo_arb_pkg.sv
package duo_arb_pkg;

  // Action taken on the grant register at a clock edge.
  typedef enum logic [1:0] {
    GA_HOLD,
    GA_FILL,
    GA_SWAP,
    GA_DROP
  } gnt_act_e;

endpackage

// File: rtl/dr_ring_pick.sv
// Rotating first-found search: returns the first set candidate strictly after ptr.
module dr_ring_pick #(
  parameter int W  = 9,
  parameter int IW = 4
) (
  input  logic [W-1:0]  cand,
  input  logic [IW-1:0] ptr,
  output logic          hit,
  output logic [IW-1:0] idx
);

  always_comb begin
    logic [IW-1:0] pos;
    hit = 1'b0;
    idx = '0;
    pos = '0;
    for (int k = 1; k <= W; k++) begin
      pos = IW'((int'(ptr) + k) % W);
      if (!hit && cand[pos]) begin
        hit = 1'b1;
        idx = pos;
      end
    end
  end

endmodule

// File: rtl/dr_ring_ptrs.sv
// Rotation pointers for both rings plus the last-initiator register.
module dr_ring_ptrs #(
  parameter int NUM_MASTERS = 9,
  parameter int IW          = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_n,
  input  logic          owner_vld,
  input  logic [IW-1:0] owner_idx,
  input  logic          owner_hi,
  output logic [IW-1:0] hi_eff,
  output logic [IW-1:0] lo_eff,
  output logic [IW-1:0] last_user
);

  localparam logic [IW-1:0] LOW_SLOT = IW'(NUM_MASTERS);
  localparam logic [IW-1:0] LO_INIT  = IW'(NUM_MASTERS - 1);

  logic          frame_q;
  logic          txn_start;
  logic          take;
  logic [IW-1:0] hi_q, lo_q, last_q;
  logic [IW-1:0] hi_nxt, lo_nxt, last_nxt;

  assign txn_start = frame_q && !frame_n;
  assign take      = txn_start && owner_vld;

  always_comb begin
    hi_nxt   = hi_q;
    lo_nxt   = lo_q;
    last_nxt = last_q;
    if (take) begin
      last_nxt = owner_idx;
      if (owner_hi) begin
        hi_nxt = owner_idx;
      end else begin
        hi_nxt = LOW_SLOT;
        lo_nxt = owner_idx;
      end
    end
  end

  // Arbitration in the start cycle already sees the rotated pointers.
  assign hi_eff    = hi_nxt;
  assign lo_eff    = lo_nxt;
  assign last_user = last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b1;
      hi_q    <= LOW_SLOT;
      lo_q    <= LO_INIT;
      last_q  <= '0;
    end else begin
      frame_q <= frame_n;
      hi_q    <= hi_nxt;
      lo_q    <= lo_nxt;
      last_q  <= last_nxt;
    end
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_start |=> ($stable(hi_q) && $stable(lo_q))); // R11

endmodule

// File: rtl/dr_grant_seq.sv
// Grant register with bus-state-dependent hand-over spacing.
module dr_grant_seq
  import duo_arb_pkg::*;
#(
  parameter int NUM_MASTERS = 9,
  parameter int IW          = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   busy,
  input  logic                   want_vld,
  input  logic [IW-1:0]          want_idx,
  input  logic                   park_local,
  input  logic [IW-1:0]          last_user,
  output logic [NUM_MASTERS-1:0] gnt_q
);

  localparam logic [NUM_MASTERS-1:0] BRIDGE_OH = NUM_MASTERS'(1);

  logic [IW-1:0]          tgt_idx;
  logic [NUM_MASTERS-1:0] tgt_oh;
  gnt_act_e               act;

  always_comb begin
    if (want_vld)        tgt_idx = want_idx;
    else if (park_local) tgt_idx = '0;
    else                 tgt_idx = last_user;
  end

  always_comb begin
    tgt_oh = '0;
    for (int i = 0; i < NUM_MASTERS; i++) begin
      if (tgt_idx == IW'(i)) tgt_oh[i] = 1'b1;
    end
  end

  always_comb begin
    if (gnt_q == tgt_oh)   act = GA_HOLD;
    else if (gnt_q == '0)  act = GA_FILL;
    else if (busy)         act = GA_SWAP;
    else                   act = GA_DROP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q <= BRIDGE_OH;
    end else begin
      case (act)
        GA_FILL, GA_SWAP: gnt_q <= tgt_oh;
        GA_DROP:          gnt_q <= '0;
        default:          gnt_q <= gnt_q;
      endcase
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q)); // R2
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && gnt_q != '0) |=> (gnt_q == $past(gnt_q) || gnt_q == '0)); // R8
  AST_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q == '0) |=> (gnt_q != '0)); // R8

endmodule

// File: rtl/duo_ring_arbiter.sv
// Nine-master arbiter: high ring with the whole low ring as one extra slot.
module duo_ring_arbiter #(
  parameter int NUM_MASTERS = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req_n,
  input  logic                   frame_n,
  input  logic                   irdy_n,
  input  logic [NUM_MASTERS-1:0] prio_hi,
  input  logic                   park_local,
  output logic [NUM_MASTERS-1:0] gnt_n
);

  localparam int SLOTS = NUM_MASTERS + 1;
  localparam int IW    = $clog2(SLOTS);
  localparam logic [IW-1:0] LOW_SLOT = IW'(NUM_MASTERS);

  logic [NUM_MASTERS-1:0] req_act;
  logic [SLOTS-1:0]       hi_cand;
  logic [NUM_MASTERS-1:0] lo_cand;
  logic                   hi_hit, lo_hit;
  logic [IW-1:0]          hi_idx, lo_idx;
  logic [IW-1:0]          hi_eff, lo_eff, last_user;
  logic                   want_vld;
  logic [IW-1:0]          want_idx;
  logic [NUM_MASTERS-1:0] gnt_q;
  logic                   owner_vld, owner_hi;
  logic [IW-1:0]          owner_idx;
  logic                   busy;

  assign req_act = ~req_n;
  assign busy    = !frame_n || !irdy_n;
  assign lo_cand = req_act & ~prio_hi;
  assign hi_cand = {|lo_cand, req_act & prio_hi};

  dr_ring_pick #(.W(SLOTS), .IW(IW)) u_hi_pick (
    .cand (hi_cand),
    .ptr  (hi_eff),
    .hit  (hi_hit),
    .idx  (hi_idx)
  );

  dr_ring_pick #(.W(NUM_MASTERS), .IW(IW)) u_lo_pick (
    .cand (lo_cand),
    .ptr  (lo_eff),
    .hit  (lo_hit),
    .idx  (lo_idx)
  );

  always_comb begin
    if (hi_idx == LOW_SLOT) begin
      want_vld = hi_hit && lo_hit;
      want_idx = lo_idx;
    end else begin
      want_vld = hi_hit;
      want_idx = hi_idx;
    end
  end

  always_comb begin
    owner_idx = '0;
    for (int i = 0; i < NUM_MASTERS; i++) begin
      if (gnt_q[i]) owner_idx = IW'(i);
    end
  end
  assign owner_vld = |gnt_q;
  assign owner_hi  = |(gnt_q & prio_hi);

  dr_ring_ptrs #(.NUM_MASTERS(NUM_MASTERS), .IW(IW)) u_ptrs (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .owner_vld (owner_vld),
    .owner_idx (owner_idx),
    .owner_hi  (owner_hi),
    .hi_eff    (hi_eff),
    .lo_eff    (lo_eff),
    .last_user (last_user)
  );

  dr_grant_seq #(.NUM_MASTERS(NUM_MASTERS), .IW(IW)) u_grant (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .want_vld   (want_vld),
    .want_idx   (want_idx),
    .park_local (park_local),
    .last_user  (last_user),
    .gnt_q      (gnt_q)
  );

  assign gnt_n = ~gnt_q;

  AST_PARK_BRIDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (&req_n && park_local && !gnt_n[0]) |=> !gnt_n[0]); // R10

endmodule

// File: tb/test_duo_ring_arbiter.sv
module test_duo_ring_arbiter;
  localparam int N = 9;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req_n = '1;
  logic [N-1:0] prio_hi = 9'h001;
  logic [N-1:0] gnt_n;
  logic         frame_n = 1'b1;
  logic         irdy_n = 1'b1;
  logic         park_local = 1'b0;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int starters[$];

  // reference model state
  int   m_gnt, m_hi, m_lo, m_last;
  logic m_pf;

  always #5 clk = ~clk;

  duo_ring_arbiter #(.NUM_MASTERS(N)) i_duo_ring_arbiter (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n),
    .irdy_n(irdy_n), .prio_hi(prio_hi), .park_local(park_local), .gnt_n(gnt_n)
  );

  function automatic int model_pick();
    for (int k = 1; k <= N + 1; k++) begin
      int p = (m_hi + k) % (N + 1);
      if (p < N) begin
        if (prio_hi[p] && !req_n[p]) return p;
      end else begin
        for (int j = 1; j <= N; j++) begin
          int q = (m_lo + j) % N;
          if (!prio_hi[q] && !req_n[q]) return q;
        end
      end
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_gnt = 0; m_hi = N; m_lo = N - 1; m_last = 0; m_pf = 1'b1;
    end else begin
      int want, tgt;
      if (!frame_n && m_pf && m_gnt >= 0) begin
        if (prio_hi[m_gnt]) m_hi = m_gnt;
        else begin m_hi = N; m_lo = m_gnt; end
        m_last = m_gnt;
      end
      m_pf = frame_n;
      want = model_pick();
      tgt = (want >= 0) ? want : (park_local ? 0 : m_last);
      if (m_gnt != tgt) begin
        if (m_gnt < 0 || !frame_n || !irdy_n) m_gnt = tgt;
        else m_gnt = -1;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int gidx();
    int found = -1;
    int cnt = 0;
    for (int i = 0; i < N; i++) if (!gnt_n[i]) begin found = i; cnt++; end
    return (cnt > 1) ? -2 : found;
  endfunction

  task automatic cycle();
    @(negedge clk);
    if (rst_n) begin
      chk("R2 one grant", int'($countones(~gnt_n) <= 1), 1);
      chk("R6/R7/R8/R9 model", gidx(), m_gnt);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 bridge during reset", int'(gnt_n), 9'h1FE);
    rst_n = 1'b1;
  endtask

  task automatic txn();
    frame_n = 1'b0; cycle();
    frame_n = 1'b1; irdy_n = 1'b0; cycle();
    irdy_n = 1'b1; cycle();
  endtask

  task automatic serve(input int cnt);
    int got = 0;
    int guard = 0;
    starters.delete();
    while (got < cnt && guard < 3000) begin
      int g;
      cycle();
      guard++;
      g = gidx();
      if (g >= 0 && !req_n[g]) begin
        starters.push_back(g);
        got++;
        txn();
      end
    end
  endtask

  initial begin
    // R1: reset parks on bridge
    prio_hi = 9'h001; req_n = '1; park_local = 1'b0;
    do_reset();
    cycle();
    chk("R1 bridge after reset", gidx(), 0);
    cycle();
    chk("R9 idle park after reset", gidx(), 0);

    // R3: default groups, all requesting
    req_n = '0;
    serve(16);
    for (int i = 0; i < 16; i++)
      chk("R3 alternation", starters[i], (i % 2 == 0) ? 0 : ((i / 2) % 8) + 1);

    // R4: mixed groups
    prio_hi = 9'h00F; req_n = '0;
    do_reset();
    serve(15);
    for (int i = 0; i < 15; i++)
      chk("R4 nested order", starters[i], (i % 5 < 4) ? (i % 5) : 4 + (i / 5) % 5);

    // R5: flat rotation, all high then all low
    prio_hi = 9'h1FF;
    do_reset();
    serve(18);
    for (int i = 0; i < 18; i++) chk("R5 flat all high", starters[i], i % 9);
    prio_hi = 9'h000;
    do_reset();
    serve(18);
    for (int i = 0; i < 18; i++) chk("R5 flat all low", starters[i], i % 9);

    // R6: last initiator drops to lowest
    prio_hi = 9'h1FF; req_n = '1; req_n[2] = 1'b0; req_n[4] = 1'b0;
    do_reset();
    serve(4);
    chk("R6 first", starters[0], 2);
    chk("R6 second", starters[1], 4);
    chk("R6 third", starters[2], 2);
    chk("R6 fourth", starters[3], 4);

    // R7/R8: idle hand-over with gap, preemption by higher priority
    prio_hi = 9'h001; req_n = '1;
    do_reset();
    cycle();
    req_n[5] = 1'b0;
    cycle(); chk("R8 idle gap", gidx(), -1);
    cycle(); chk("R7 grant to requester", gidx(), 5);
    req_n[0] = 1'b0;
    cycle(); chk("R7 withdraw for higher", gidx(), -1);
    cycle(); chk("R7 higher granted next clock", gidx(), 0);
    // busy: direct switch
    req_n[0] = 1'b1; irdy_n = 1'b0;
    cycle(); chk("R8 busy direct switch", gidx(), 5);
    irdy_n = 1'b1;
    cycle();

    // R11: request churn without a start keeps pointers
    prio_hi = 9'h1FF; req_n = '1; req_n[2] = 1'b0; req_n[5] = 1'b0;
    do_reset();
    repeat (4) cycle();
    chk("R11 initial winner", gidx(), 2);
    req_n[2] = 1'b1;
    repeat (4) cycle();
    chk("R11 moved away", gidx(), 5);
    req_n[2] = 1'b0;
    repeat (4) cycle();
    chk("R11 no rotation without start", gidx(), 2);

    // R9/R10: parking on last user, then forced on bridge
    prio_hi = 9'h001; req_n = '1; req_n[6] = 1'b0;
    do_reset();
    repeat (4) cycle();
    chk("R9 granted before txn", gidx(), 6);
    frame_n = 1'b0; cycle();
    req_n[6] = 1'b1; frame_n = 1'b1; irdy_n = 1'b0; cycle();
    irdy_n = 1'b1;
    repeat (5) cycle();
    chk("R9 parked on last user", gidx(), 6);
    park_local = 1'b1;
    repeat (4) cycle();
    chk("R10 parked on bridge", gidx(), 0);
    park_local = 1'b0;
    cycle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule